// File: doc/BRIEF.md
# Interval Averaging Accumulator

The block averages a stream of signed, already digitized samples over a window of 2^n milliseconds. It writes the average into a 16-bit two's-complement result word as a signed count whose upper ten bits hold the value. The analog front end and the multiplier sit outside the block. Three sample inputs carry their outputs: one for power, one for voltage and one for current. An 8-bit configuration word chooses among them. The same word sets the window exponent, chooses whether windows are counted in internal-rate or external-rate sample ticks, and can put the block into shutdown.

One window holds 2^(BASE_LOG2+n) samples at the internal rate, or 2^(BASE_LOG2+1+n) samples at the external rate. BASE_LOG2 is 9 by default, which gives 512 or 1024 samples per millisecond. The average is the window sum shifted right arithmetically by the log2 of the sample count. It is clamped to the reportable range and loaded into the result word. In the same cycle a one-cycle new-data pulse is raised. The configuration is captured only at window boundaries, so a write takes effect after the window in progress has finished.

Top module: `avg_window_top`

## Requirements
- R1: After reset the result word is 0 and the new-data pulse is low. The first window starts one cycle after reset is released and uses the current configuration word; with a configuration of 0 this is n=0, internal rate and power.
- R2: A window is 2^(BASE_LOG2+n) ticks long, where n comes from configuration bits [3:0]. A value of n above 8 is treated as 8. With ticks arriving every cycle, successive new-data pulses are exactly one window apart.
- R3: The reported average is floor(window sum / window sample count), formed by an arithmetic right shift.
- R4: The average is clamped to the range -256..+256 in power and current modes, and to 0..+256 in voltage mode.
- R5: The result word holds the clamped count in bits [15:6] and zeros in bits [5:0]. +256 reads 16'h4000 and -256 reads 16'hC000.
- R6: Configuration bits [7:6] pick the averaged input: 00 power, 01 voltage, 10 current. The reserved value 11 behaves as power.
- R7: Configuration bit 5 set to 1 counts windows on the external tick input. Each window then holds twice as many samples, 2^(BASE_LOG2+1+n). With bit 5 at 0, the internal tick input is counted.
- R8: The new-data pulse lasts one cycle. It is high in the same cycle that the result word first shows the new average.
- R9: A configuration change made during a window does not affect that window. The window ends with the old settings, and the next window uses the new ones.
- R10: Configuration bit 4 set to 1 puts the block in shutdown: the sum is cleared, no new-data pulse is raised and the result word holds its value. When bit 4 returns to 0, a fresh full window starts after one capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 8 | Configuration: [3:0] n, [4] shutdown, [5] external rate, [7:6] quantity |
| intTick | input | 1 | Internal-rate sample enable |
| extTick | input | 1 | External-rate sample enable |
| powerSample | input | SAMPLE_W | Signed power sample |
| voltSample | input | SAMPLE_W | Signed voltage sample |
| currSample | input | SAMPLE_W | Signed current sample |
| resultWord | output | 16 | Left-aligned averaged count |
| newData | output | 1 | One-cycle pulse when a new average is loaded |

## Verification
The assertions rely on three properties of the inputs. The configuration word must change only at clock edges. Tick inputs must be synchronous enables. Samples must stay within SAMPLE_W signed bits, so the accumulator, which has one guard bit, cannot wrap before it is shifted. The stimulus drives every input at the falling edge and keeps all sample values well inside the 12-bit range; the saturation cases use ±1500. Tick inputs are held high, so each window's sample count equals its cycle count. Each sample input alternates between two values every cycle, and because windows always have an even length, every window holds the same number of each value, which gives a closed-form floor average.

// File: rtl/avg_pkg.sv
package avg_pkg;
  localparam int MAX_N   = 8;
  localparam int SHIFT_W = 6;

  typedef enum logic [1:0] {
    MODE_POWER = 2'b00,
    MODE_VOLT  = 2'b01,
    MODE_CURR  = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  typedef struct packed {
    logic               clear;
    logic               accum;
    logic               finish;
    mode_e              mode;
    logic [SHIFT_W-1:0] shift;
  } ctrl_s;
endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
  import avg_pkg::*;
#(
  parameter int BASE_LOG2 = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cfgWord,
  input  logic       intTick,
  input  logic       extTick,
  output ctrl_s      ctrlOut
);
  localparam int CNT_W = BASE_LOG2 + 1 + MAX_N;

  logic             running;
  logic [3:0]       actN;
  logic             actExt;
  mode_e            actMode;
  logic [CNT_W-1:0] sampleCnt;
  logic [CNT_W-1:0] lastIdx;
  logic [3:0]       cfgN;
  mode_e            cfgMode;
  logic             shdn;
  logic             tick;
  logic [SHIFT_W-1:0] shiftAmt;

  always_comb begin
    shdn    = cfgWord[4];
    cfgN    = (cfgWord[3:0] > 4'(MAX_N)) ? 4'(MAX_N) : cfgWord[3:0];
    cfgMode = (cfgWord[7:6] == 2'b11) ? MODE_POWER : mode_e'(cfgWord[7:6]);
    tick    = actExt ? extTick : intTick;
    shiftAmt = SHIFT_W'(BASE_LOG2) + SHIFT_W'(actExt) + SHIFT_W'(actN);
    lastIdx = CNT_W'((32'd1 << shiftAmt) - 32'd1);
    ctrlOut.clear  = shdn | ~running;
    ctrlOut.accum  = running & ~shdn & tick;
    ctrlOut.finish = running & ~shdn & tick & (sampleCnt == lastIdx);
    ctrlOut.mode   = actMode;
    ctrlOut.shift  = shiftAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      actN      <= '0;
      actExt    <= 1'b0;
      actMode   <= MODE_POWER;
      sampleCnt <= '0;
    end else if (shdn) begin
      running   <= 1'b0;
      sampleCnt <= '0;
    end else if (!running || ctrlOut.finish) begin
      running   <= 1'b1;
      sampleCnt <= '0;
      actN      <= cfgN;
      actExt    <= cfgWord[5];
      actMode   <= cfgMode;
    end else if (ctrlOut.accum) begin
      sampleCnt <= sampleCnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    sampleCnt <= lastIdx); // R2
  AST_N_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    actN <= 4'(MAX_N)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (running && !shdn && !ctrlOut.finish) |=> $stable({actN, actExt, actMode})); // R9
  AST_SHDN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    shdn |=> (sampleCnt == '0 && !running)); // R10
endmodule

// File: rtl/avg_datapath.sv
module avg_datapath
  import avg_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int BASE_LOG2 = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_s               ctrlIn,
  input  logic [SAMPLE_W-1:0] powerSample,
  input  logic [SAMPLE_W-1:0] voltSample,
  input  logic [SAMPLE_W-1:0] currSample,
  output logic [15:0]         resultWord,
  output logic                newData
);
  localparam int ACC_W = SAMPLE_W + BASE_LOG2 + 1 + MAX_N + 1;
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'(256);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -ACC_W'(256);

  logic signed [ACC_W-1:0]    acc;
  logic signed [ACC_W-1:0]    sumNext;
  logic signed [ACC_W-1:0]    avgFull;
  logic signed [ACC_W-1:0]    loLim;
  logic signed [ACC_W-1:0]    clamped;
  logic        [SAMPLE_W-1:0] sel;

  always_comb begin
    case (ctrlIn.mode)
      MODE_VOLT: sel = voltSample;
      MODE_CURR: sel = currSample;
      default:   sel = powerSample;
    endcase
    sumNext = acc + {{(ACC_W-SAMPLE_W){sel[SAMPLE_W-1]}}, sel};
    avgFull = sumNext >>> ctrlIn.shift;
    loLim   = (ctrlIn.mode == MODE_VOLT) ? '0 : NEG_LIM;
    if (avgFull > POS_LIM)      clamped = POS_LIM;
    else if (avgFull < loLim)   clamped = loLim;
    else                        clamped = avgFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc        <= '0;
      resultWord <= '0;
      newData    <= 1'b0;
    end else begin
      newData <= ctrlIn.finish;
      if (ctrlIn.clear) begin
        acc <= '0;
      end else if (ctrlIn.finish) begin
        acc        <= '0;
        resultWord <= {clamped[9:0], 6'b0};
      end else if (ctrlIn.accum) begin
        acc <= sumNext;
      end
    end
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    resultWord[5:0] == 6'b0); // R5
  AST_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    newData |-> ($signed(resultWord[15:6]) >= -10'sd256 && $signed(resultWord[15:6]) <= 10'sd256)); // R4
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.finish |=> $stable(resultWord)); // R10
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (newData && ctrlIn.shift > 0) |=> !newData); // R8
endmodule

// File: rtl/avg_window_top.sv
module avg_window_top
  import avg_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int BASE_LOG2 = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          cfgWord,
  input  logic                intTick,
  input  logic                extTick,
  input  logic [SAMPLE_W-1:0] powerSample,
  input  logic [SAMPLE_W-1:0] voltSample,
  input  logic [SAMPLE_W-1:0] currSample,
  output logic [15:0]         resultWord,
  output logic                newData
);
  ctrl_s ctrlBus;

  avg_ctrl #(.BASE_LOG2(BASE_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord),
    .intTick(intTick), .extTick(extTick), .ctrlOut(ctrlBus)
  );

  avg_datapath #(.SAMPLE_W(SAMPLE_W), .BASE_LOG2(BASE_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlBus),
    .powerSample(powerSample), .voltSample(voltSample), .currSample(currSample),
    .resultWord(resultWord), .newData(newData)
  );
endmodule

// File: tb/sim_avg_window_top.sv
`timescale 1ns/1ps
module sim_avg_window_top;
  localparam int SW = 12;
  localparam int BL = 2;

  logic          clk = 0;
  logic          rstN = 0;
  logic [7:0]    cfgWord = 0;
  logic          intTick = 1, extTick = 1;
  logic [SW-1:0] powerSample = 0, voltSample = 0, currSample = 0;
  logic [15:0]   resultWord;
  logic          newData;

  int checks = 0, failures = 0;
  int pA = 0, pB = 0, vA = 0, vB = 0, cA = 0, cB = 0;
  bit phase = 0;
  bit done = 0;

  always #5 clk = ~clk;

  avg_window_top #(.SAMPLE_W(SW), .BASE_LOG2(BL)) u0 (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .intTick(intTick), .extTick(extTick),
    .powerSample(powerSample), .voltSample(voltSample), .currSample(currSample),
    .resultWord(resultWord), .newData(newData)
  );

  always @(negedge clk) begin
    phase <= ~phase;
    powerSample <= SW'(phase ? pA : pB);
    voltSample  <= SW'(phase ? vA : vB);
    currSample  <= SW'(phase ? cA : cB);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic waitStrobe(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!newData && cyc < 5000);
    if (cyc >= 5000) check(0, "strobe timeout", cyc, 0);
  endtask

  function automatic int expAvg(int a, int b, bit volt);
    int s = a + b;
    int e = (s >= 0) ? s / 2 : -((1 - s) / 2);
    int lo = volt ? 0 : -256;
    if (e > 256) e = 256;
    if (e < lo) e = lo;
    return e;
  endfunction

  function automatic int expWord(int e);
    logic [9:0] v = 10'(e);
    return int'({v, 6'b0});
  endfunction

  function automatic logic [7:0] mkCfg(int mode, bit ext, bit shdn, int n);
    return {2'(mode), ext, shdn, 4'(n)};
  endfunction

  task automatic runCase(input logic [7:0] cfg, input int e, input int period, input string req);
    int c;
    cfgWord = cfg;
    waitStrobe(c);
    waitStrobe(c);
    check(resultWord == 16'(expWord(e)), req, resultWord, expWord(e));
    waitStrobe(c);
    check(c == period, {req, " period"}, c, period);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c, e, hold;
    pA = 100; pB = 51;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(resultWord == 16'h0, "R1 reset result", resultWord, 0);
    check(newData == 1'b0, "R1 reset strobe", newData, 0);
    rstN = 1;
    waitStrobe(c);
    check(c == (1 << BL) + 1, "R1 first window length", c, (1 << BL) + 1);
    check(resultWord == 16'(expWord(75)), "R1 R3 default power average", resultWord, expWord(75));
    @(negedge clk);
    check(newData == 1'b0, "R8 single-cycle pulse", newData, 0);

    // R2 R3 R7 sweep of n and rate, power mode
    for (int ext = 0; ext < 2; ext++) begin
      for (int n = 0; n <= 8; n++) begin
        pA = -200 + 45 * n + 9 * ext;
        pB = 31 - 17 * n;
        runCase(mkCfg(0, ext[0], 0, n), expAvg(pA, pB, 0), 1 << (BL + ext + n), "R2 R3 R7 sweep");
      end
    end

    // R2 clamp of n above 8
    pA = 7; pB = 8;
    runCase(mkCfg(0, 0, 0, 12), expAvg(7, 8, 0), 1 << (BL + 8), "R2 n clamp");

    // R6 R4 R5 mode selection and saturation
    pA = 60; pB = 61; vA = 200; vB = 100; cA = -40; cB = -41;
    runCase(mkCfg(1, 0, 0, 0), 150, 4, "R6 voltage select");
    runCase(mkCfg(2, 0, 0, 0), -41, 4, "R6 current select");
    runCase(mkCfg(0, 0, 0, 0), 60, 4, "R6 power select");
    runCase(mkCfg(3, 0, 0, 0), 60, 4, "R6 reserved as power");
    vA = -50; vB = -30;
    runCase(mkCfg(1, 0, 0, 0), 0, 4, "R4 voltage floor");
    cA = -1500; cB = -1500;
    runCase(mkCfg(2, 0, 0, 0), -256, 4, "R4 R5 negative clamp C000");
    check(resultWord == 16'hC000, "R5 minus full scale word", resultWord, 16'hC000);
    pA = 1500; pB = 1400;
    runCase(mkCfg(3, 1, 0, 1), 256, 16, "R4 R5 positive clamp 4000");
    check(resultWord == 16'h4000, "R5 plus full scale word", resultWord, 16'h4000);
    pA = 256; pB = 256;
    runCase(mkCfg(0, 0, 0, 0), 256, 4, "R4 exact full scale");

    // R9 deferral of a mid-window change
    pA = 90; pB = -10; vA = 33; vB = 35;
    cfgWord = mkCfg(0, 0, 0, 6);
    waitStrobe(c); waitStrobe(c);
    repeat (50) @(negedge clk);
    cfgWord = mkCfg(1, 0, 0, 0);
    waitStrobe(c);
    check(resultWord == 16'(expWord(40)), "R9 window ends with old mode", resultWord, expWord(40));
    check(c == 256 - 50, "R9 window ends with old length", c, 256 - 50);
    waitStrobe(c);
    check(resultWord == 16'(expWord(34)), "R9 new mode next window", resultWord, expWord(34));
    check(c == 4, "R9 new length next window", c, 4);

    // R10 shutdown
    hold = resultWord;
    cfgWord = mkCfg(1, 0, 1, 0);
    vA = 120; vB = 120;
    e = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (newData) e++;
    end
    check(e == 0, "R10 no strobe in shutdown", e, 0);
    check(int'(resultWord) == hold, "R10 result held", resultWord, hold);
    cfgWord = mkCfg(1, 0, 0, 0);
    waitStrobe(c);
    check(c == 5, "R10 fresh window after restart", c, 5);
    check(resultWord == 16'(expWord(120)), "R10 average after restart", resultWord, expWord(120));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule